// File: doc/BRIEF.md
# USB Full-Speed Device Link State Tracker

This block follows a USB full-speed device through attach, bus reset, enumeration traffic, suspend and resume, and keeps one registered state. Its inputs are already-qualified levels and one-cycle events: a filtered supply-present level, the pull-up enable, a bus reset event, bus-activity and bus-idle events, a request to resume straight towards the active state, a received-J indication and a start-of-frame strobe. The timers that produce those events sit elsewhere. This block only sequences them.

Two kinds of suspend are kept apart. One is a suspend entered while the device is powered but has never seen a bus reset. The other is a suspend entered after the link has gone active. The active phase is also split: one state covers the time after a bus reset but before any frame marker has arrived, and another covers the time after one has. Four status flags and a 3-bit state code are decoded from the state for the rest of the device.

Top module: `usb_link_tracker`

## Requirements
- R1: A synchronous active-high reset puts the tracker in the detached state. The state code is 0 = detached, 1 = powered, 2 = powered-suspended, 3 = resuming, 4 = active-before-frame, 5 = active, 6 = suspended. Code 7 is never held: if it appears, the next state is detached.
- R2: In any state, if the supply level or the pull-up enable is low at a clock edge, the next state is detached. This rule overrides every other event.
- R3: Detached moves to powered only when the supply level and the pull-up enable are both high.
- R4: In powered, a bus reset goes to active-before-frame. Failing that, a resume request goes to resuming. Failing that, a bus-idle event goes to powered-suspended.
- R5: In powered-suspended, a bus reset goes to active-before-frame. Failing that, a bus-activity event goes back to powered.
- R6: Resuming goes to active-before-frame on received-J or on a bus reset. Other events leave it in place.
- R7: In active-before-frame, a bus-idle event goes to suspended. Failing that, a start-of-frame strobe goes to active.
- R8: In active, a bus-idle event goes to suspended. Failing that, a bus reset goes to active-before-frame.
- R9: In suspended, a bus reset goes to active-before-frame. Failing that, a bus-activity event goes to resuming. Received-J and start-of-frame have no effect there.
- R10: The detached flag is high only in detached. The suspended flag is high in powered-suspended and suspended. The active flag is high in active-before-frame and active.
- R11: The powered flag is the live supply level ANDed with (state is powered OR the active flag is high). It therefore drops in the same cycle as the supply level.
- R12: When bus activity is reported one or more cycles before the bus reset it belongs to, a suspended link still ends in active-before-frame. The path runs through resuming from suspended, or through powered from powered-suspended.
- R13: With no event that the current state responds to, the state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vbus_ok_i | input | 1 | Filtered supply-present level |
| pullup_en_i | input | 1 | Pull-up enable level |
| bus_reset_i | input | 1 | Bus reset event |
| bus_active_i | input | 1 | Bus activity seen after idle |
| bus_idle_i | input | 1 | Bus idle long enough to suspend |
| resume_req_i | input | 1 | Request to move from powered to resuming |
| rx_j_i | input | 1 | J state received |
| sof_seen_i | input | 1 | Start-of-frame strobe |
| st_detached_o | output | 1 | Detached flag |
| st_powered_o | output | 1 | Powered flag |
| st_suspended_o | output | 1 | Suspended flag (either kind) |
| st_active_o | output | 1 | Active flag (either kind) |
| state_code_o | output | 3 | Encoded state, values as in R1 |

## Verification
The properties assume the inputs change only between clock edges and are stable at each rising edge. They also assume the events are free to coincide in any combination, because every transition property names the higher-priority events it excludes. The stimulus changes inputs only on the falling edge. It deliberately presents coinciding events (idle with reset, activity with reset, resume with idle) so that every priority rule is exercised. Bus activity is reported ahead of its reset in both suspend states to cover the late-reset case.

// File: rtl/usb_link_pkg.sv
package usb_link_pkg;

    localparam int unsigned LINK_CODE_W = 3;

    typedef enum logic [LINK_CODE_W-1:0] {
        LNK_DETACHED    = 3'd0,
        LNK_POWERED     = 3'd1,
        LNK_PWR_SUSPEND = 3'd2,
        LNK_RESUMING    = 3'd3,
        LNK_ACT_NOFRAME = 3'd4,
        LNK_ACTIVE      = 3'd5,
        LNK_SUSPENDED   = 3'd6
    } link_state_e;

    typedef struct packed {
        logic attached;
        logic bus_reset;
        logic bus_active;
        logic bus_idle;
        logic resume_req;
        logic rx_j;
        logic sof;
    } link_evt_t;

    typedef struct packed {
        logic detached;
        logic powered;
        logic suspended;
        logic active;
    } link_flags_t;

    function automatic logic is_active_state(link_state_e s);
        return (s == LNK_ACT_NOFRAME) || (s == LNK_ACTIVE);
    endfunction

    function automatic logic is_suspend_state(link_state_e s);
        return (s == LNK_PWR_SUSPEND) || (s == LNK_SUSPENDED);
    endfunction

endpackage

// File: rtl/link_evt_pack.sv
module link_evt_pack
    import usb_link_pkg::*;
(
    input  logic      vbus_ok,
    input  logic      pullup_en,
    input  logic      bus_reset,
    input  logic      bus_active,
    input  logic      bus_idle,
    input  logic      resume_req,
    input  logic      rx_j,
    input  logic      sof,
    output link_evt_t evt
);
    always_comb begin
        evt.attached   = vbus_ok & pullup_en;
        evt.bus_reset  = bus_reset;
        evt.bus_active = bus_active;
        evt.bus_idle   = bus_idle;
        evt.resume_req = resume_req;
        evt.rx_j       = rx_j;
        evt.sof        = sof;
    end
endmodule

// File: rtl/link_next_state.sv
module link_next_state
    import usb_link_pkg::*;
(
    input  link_state_e cur,
    input  link_evt_t   evt,
    output link_state_e nxt
);
    always_comb begin
        nxt = cur;
        if (!evt.attached) begin
            nxt = LNK_DETACHED;
        end else begin
            unique case (cur)
                LNK_DETACHED: nxt = LNK_POWERED;
                LNK_POWERED: begin
                    if (evt.bus_reset)       nxt = LNK_ACT_NOFRAME;
                    else if (evt.resume_req) nxt = LNK_RESUMING;
                    else if (evt.bus_idle)   nxt = LNK_PWR_SUSPEND;
                end
                LNK_PWR_SUSPEND: begin
                    if (evt.bus_reset)       nxt = LNK_ACT_NOFRAME;
                    else if (evt.bus_active) nxt = LNK_POWERED;
                end
                LNK_RESUMING: begin
                    if (evt.rx_j || evt.bus_reset) nxt = LNK_ACT_NOFRAME;
                end
                LNK_ACT_NOFRAME: begin
                    if (evt.bus_idle)        nxt = LNK_SUSPENDED;
                    else if (evt.sof)        nxt = LNK_ACTIVE;
                end
                LNK_ACTIVE: begin
                    if (evt.bus_idle)        nxt = LNK_SUSPENDED;
                    else if (evt.bus_reset)  nxt = LNK_ACT_NOFRAME;
                end
                LNK_SUSPENDED: begin
                    if (evt.bus_reset)       nxt = LNK_ACT_NOFRAME;
                    else if (evt.bus_active) nxt = LNK_RESUMING;
                end
                default: nxt = LNK_DETACHED;
            endcase
        end
    end
endmodule

// File: rtl/link_status_decode.sv
module link_status_decode
    import usb_link_pkg::*;
(
    input  link_state_e cur,
    input  logic        vbus_ok,
    output link_flags_t flags
);
    logic act;

    always_comb begin
        act             = is_active_state(cur);
        flags.detached  = (cur == LNK_DETACHED);
        flags.suspended = is_suspend_state(cur);
        flags.active    = act;
        flags.powered   = vbus_ok & ((cur == LNK_POWERED) | act);
    end
endmodule

// File: rtl/usb_link_tracker.sv
module usb_link_tracker
    import usb_link_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   vbus_ok_i,
    input  logic                   pullup_en_i,
    input  logic                   bus_reset_i,
    input  logic                   bus_active_i,
    input  logic                   bus_idle_i,
    input  logic                   resume_req_i,
    input  logic                   rx_j_i,
    input  logic                   sof_seen_i,
    output logic                   st_detached_o,
    output logic                   st_powered_o,
    output logic                   st_suspended_o,
    output logic                   st_active_o,
    output logic [LINK_CODE_W-1:0] state_code_o
);
    link_evt_t   evt;
    link_state_e state_q;
    link_state_e state_d;
    link_flags_t flags;

    link_evt_pack u_pack (
        .vbus_ok    (vbus_ok_i),
        .pullup_en  (pullup_en_i),
        .bus_reset  (bus_reset_i),
        .bus_active (bus_active_i),
        .bus_idle   (bus_idle_i),
        .resume_req (resume_req_i),
        .rx_j       (rx_j_i),
        .sof        (sof_seen_i),
        .evt        (evt)
    );

    link_next_state u_next (
        .cur (state_q),
        .evt (evt),
        .nxt (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= LNK_DETACHED;
        else     state_q <= state_d;
    end

    link_status_decode u_dec (
        .cur     (state_q),
        .vbus_ok (vbus_ok_i),
        .flags   (flags)
    );

    assign st_detached_o  = flags.detached;
    assign st_powered_o   = flags.powered;
    assign st_suspended_o = flags.suspended;
    assign st_active_o    = flags.active;
    assign state_code_o   = state_q;
endmodule

// File: rtl/usb_link_tracker_chk.sv
module usb_link_tracker_chk (
    input logic       clk,
    input logic       rst,
    input logic       vbus_ok_i,
    input logic       pullup_en_i,
    input logic       bus_reset_i,
    input logic       bus_active_i,
    input logic       bus_idle_i,
    input logic       resume_req_i,
    input logic       rx_j_i,
    input logic       sof_seen_i,
    input logic       st_detached_o,
    input logic       st_powered_o,
    input logic       st_suspended_o,
    input logic       st_active_o,
    input logic [2:0] state_code_o
);
    logic att;
    assign att = vbus_ok_i & pullup_en_i;

    AST_RESET_DETACHED: assert property (@(posedge clk) rst |=> state_code_o == 3'd0); // R1
    AST_DETACH_WINS: assert property (@(posedge clk) disable iff (rst) !att |=> state_code_o == 3'd0); // R2
    AST_ATTACH_POWERS: assert property (@(posedge clk) disable iff (rst) (state_code_o == 3'd0 && att) |=> state_code_o == 3'd1); // R3
    AST_POWERED_RESET: assert property (@(posedge clk) disable iff (rst) (state_code_o == 3'd1 && att && bus_reset_i) |=> state_code_o == 3'd4); // R4
    AST_PSUSP_WAKE: assert property (@(posedge clk) disable iff (rst) (state_code_o == 3'd2 && att && !bus_reset_i && bus_active_i) |=> state_code_o == 3'd1); // R5
    AST_RESUME_DONE: assert property (@(posedge clk) disable iff (rst) (state_code_o == 3'd3 && att && (rx_j_i || bus_reset_i)) |=> state_code_o == 3'd4); // R6
    AST_FIRST_FRAME: assert property (@(posedge clk) disable iff (rst) (state_code_o == 3'd4 && att && !bus_idle_i && sof_seen_i) |=> state_code_o == 3'd5); // R7
    AST_ACTIVE_IDLE: assert property (@(posedge clk) disable iff (rst) (state_code_o == 3'd5 && att && bus_idle_i) |=> state_code_o == 3'd6); // R8
    AST_SUSP_RESET: assert property (@(posedge clk) disable iff (rst) (state_code_o == 3'd6 && att && bus_reset_i) |=> state_code_o == 3'd4); // R9
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst) $onehot0({st_detached_o, st_suspended_o, st_active_o})); // R10
    AST_POWERED_NEEDS_VBUS: assert property (@(posedge clk) disable iff (rst) st_powered_o |-> vbus_ok_i); // R11
    AST_POWERED_HOLD: assert property (@(posedge clk) disable iff (rst) (state_code_o == 3'd1 && att && !bus_reset_i && !resume_req_i && !bus_idle_i) |=> state_code_o == 3'd1); // R13
endmodule

bind usb_link_tracker usb_link_tracker_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .vbus_ok_i      (vbus_ok_i),
    .pullup_en_i    (pullup_en_i),
    .bus_reset_i    (bus_reset_i),
    .bus_active_i   (bus_active_i),
    .bus_idle_i     (bus_idle_i),
    .resume_req_i   (resume_req_i),
    .rx_j_i         (rx_j_i),
    .sof_seen_i     (sof_seen_i),
    .st_detached_o  (st_detached_o),
    .st_powered_o   (st_powered_o),
    .st_suspended_o (st_suspended_o),
    .st_active_o    (st_active_o),
    .state_code_o   (state_code_o)
);

// File: tb/usb_link_tracker_test.sv
module usb_link_tracker_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vbus = 1'b0, pu = 1'b0, brst = 1'b0, bact = 1'b0, bidle = 1'b0;
    logic resq = 1'b0, rxj = 1'b0, sof = 1'b0;
    logic f_det, f_pow, f_susp, f_act;
    logic [2:0] code;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    usb_link_tracker uut (
        .clk(clk), .rst(rst), .vbus_ok_i(vbus), .pullup_en_i(pu),
        .bus_reset_i(brst), .bus_active_i(bact), .bus_idle_i(bidle),
        .resume_req_i(resq), .rx_j_i(rxj), .sof_seen_i(sof),
        .st_detached_o(f_det), .st_powered_o(f_pow),
        .st_suspended_o(f_susp), .st_active_o(f_act), .state_code_o(code)
    );

    // {req[3:0], vbus, pullup, reset, active, idle, resume, rxj, sof, expected code[2:0]}
    localparam int NV = 38;
    localparam logic [14:0] VEC [NV] = '{
        {4'd3,  8'b1000_0000, 3'd0},
        {4'd3,  8'b0100_0000, 3'd0},
        {4'd3,  8'b1100_0000, 3'd1},
        {4'd13, 8'b1100_0000, 3'd1},
        {4'd4,  8'b1100_1000, 3'd2},
        {4'd13, 8'b1100_0000, 3'd2},
        {4'd5,  8'b1101_0000, 3'd1},
        {4'd4,  8'b1100_1100, 3'd3},
        {4'd6,  8'b1101_1001, 3'd3},
        {4'd6,  8'b1100_0010, 3'd4},
        {4'd13, 8'b1101_0000, 3'd4},
        {4'd7,  8'b1100_0001, 3'd5},
        {4'd13, 8'b1100_0001, 3'd5},
        {4'd8,  8'b1110_0000, 3'd4},
        {4'd7,  8'b1100_0001, 3'd5},
        {4'd8,  8'b1110_1000, 3'd6},
        {4'd9,  8'b1101_0000, 3'd3},
        {4'd6,  8'b1110_0000, 3'd4},
        {4'd7,  8'b1110_1001, 3'd6},
        {4'd9,  8'b1111_0000, 3'd4},
        {4'd7,  8'b1100_1000, 3'd6},
        {4'd12, 8'b1101_0000, 3'd3},
        {4'd12, 8'b1110_0000, 3'd4},
        {4'd2,  8'b1000_0001, 3'd0},
        {4'd3,  8'b1100_0000, 3'd1},
        {4'd4,  8'b1110_1100, 3'd4},
        {4'd2,  8'b0111_1111, 3'd0},
        {4'd3,  8'b1100_0000, 3'd1},
        {4'd4,  8'b1100_1000, 3'd2},
        {4'd5,  8'b1111_0000, 3'd4},
        {4'd7,  8'b1100_1000, 3'd6},
        {4'd9,  8'b1100_0011, 3'd6},
        {4'd13, 8'b1100_0000, 3'd6},
        {4'd2,  8'b1000_0000, 3'd0},
        {4'd3,  8'b1100_0000, 3'd1},
        {4'd4,  8'b1100_1000, 3'd2},
        {4'd12, 8'b1101_0000, 3'd1},
        {4'd12, 8'b1110_0000, 3'd4}
    };

    function automatic string rname(input logic [3:0] n);
        case (n)
            4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
            4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
            4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
            4'd10: return "R10"; 4'd11: return "R11"; 4'd12: return "R12";
            default: return "R13";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // flags expected from the state code and live supply level (R10, R11)
    task automatic chk_flags(input int s);
        logic ea;
        ea = (s == 4) || (s == 5);
        chk("R10", "detached flag", int'(f_det), int'(s == 0));
        chk("R10", "suspended flag", int'(f_susp), int'((s == 2) || (s == 6)));
        chk("R10", "active flag", int'(f_act), int'(ea));
        chk("R11", "powered flag", int'(f_pow), int'(vbus && ((s == 1) || ea)));
    endtask

    task automatic apply(input logic [7:0] v);
        {vbus, pu, brst, bact, bidle, resq, rxj, sof} = v;
    endtask

    task automatic step(input logic [7:0] v);
        @(negedge clk);
        apply(v);
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk("R1", "state after reset", int'(code), 0);
        chk_flags(0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][10:3]);
            chk(rname(VEC[i][14:11]), $sformatf("state at vector %0d", i),
                int'(code), int'(VEC[i][2:0]));
            chk_flags(int'(VEC[i][2:0]));
        end

        // supply drop seen on the powered flag before the next edge (R11)
        step(8'b1100_0001);
        chk("R7", "frame marker after late reset", int'(code), 5);
        @(negedge clk);
        apply(8'b0100_0000);
        #1;
        chk("R11", "powered flag with supply low", int'(f_pow), 0);
        chk("R10", "active flag before edge", int'(f_act), 1);
        @(posedge clk);
        #2;
        chk("R2", "detach on supply loss", int'(code), 0);

        // mid-run reset returns to detached (R1)
        step(8'b1100_0000);
        step(8'b1110_0000);
        chk("R4", "powered to active-before-frame", int'(code), 4);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #2;
        chk("R1", "state after mid-run reset", int'(code), 0);
        chk_flags(0);
        @(negedge clk);
        rst = 1'b0;
        step(8'b1100_0000);
        chk("R3", "attach after reset", int'(code), 1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule